// File: doc/BRIEF.md
# DRAM Open Page Tracking Controller

This block remembers, for every logical bank behind every chip select of a DRAM channel, whether a row is currently open and which row it is. When a transaction arrives with a chip select, a bank and a row, the block classifies it. A page hit goes straight to a read/write command. An access to a closed bank first gets an activate. A row collision first gets a precharge and then an activate. The block issues one command per cycle on a registered command output, and it holds off new transactions with `req_ready` while a multi-command sequence is in progress.

Pages close in three ways. A refresh-due pulse closes every bank with a single precharge-all command. A bank that has seen no command for more than the programmed idle limit gets its own precharge. A row collision precharges the bank it hits. Open-page operation can be switched off in two ways: a zero idle limit switches it off everywhere, and a per-chip-select auto-precharge enable switches it off for that chip select. In either case every read/write command is issued with auto-precharge (the address bit 10 flag, `cmd_ap`), and the bank is marked closed straight after it. Timing parameters, the refresh schedule and data movement belong to other blocks.

Top module: `page_tracker`

## Requirements
- R1: After reset no command is issued (`cmd_kind` = 0, `cmd_valid` low), every `bank_open` bit is 0 and `req_ready` is 1.
- R2: A transaction to a closed bank produces an activate (`cmd_kind` = 2) carrying the requested row in the cycle after acceptance, then a read/write (`cmd_kind` = 3) in the next cycle. The bank reads as open from the activate onward.
- R3: A transaction whose row equals the open row of its bank produces a read/write as its first command, in the cycle after acceptance, with no activate.
- R4: A transaction to an open bank holding a different row produces a precharge (`cmd_kind` = 1), an activate with the new row and a read/write, in three consecutive cycles after acceptance.
- R5: With a nonzero idle limit and auto-precharge disabled for the chip select, read/write is issued with `cmd_ap` = 0 and the bank stays open.
- R6: When `ap_en` bit n is set, every read/write to chip select n carries `cmd_ap` = 1 and leaves the bank closed. Other chip selects are unaffected.
- R7: When `idle_limit` is 0, every read/write carries `cmd_ap` = 1 and leaves the bank closed, and no idle precharge is ever issued.
- R8: A bank whose last command appeared in cycle t, and which receives no further command, gets a precharge in cycle t + `idle_limit` + 1, after which it reads as closed. Any command to that bank restarts this count.
- R9: A `refresh_due` pulse produces a precharge-all (`cmd_kind` = 4) and clears every `bank_open` bit. A pulse that arrives during a sequence is remembered, and the precharge-all is issued in the first idle cycle after that sequence.
- R10: `req_ready` is 0 while an activate or read/write of an accepted sequence is still to come, and while a remembered refresh waits.
- R11: New transactions take priority over idle precharges. When several banks are past their limit, they are precharged one per cycle, lowest flat index first.
- R12: Banks are independent. The flat index is {chip select, bank}, and `bank_open` bit i shows the state of flat index i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transaction request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_cs | input | CS_W | Chip select of the request |
| req_bank | input | BANK_W | Logical bank of the request |
| req_row | input | ROW_W | Row of the request |
| refresh_due | input | 1 | One-cycle pulse: close all pages |
| ap_en | input | NUM_CS | Per-chip-select auto-precharge enable |
| idle_limit | input | IDLE_W | Idle cycles allowed before a page closes; 0 disables page mode |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 3 | 0 none, 1 precharge, 2 activate, 3 read/write, 4 precharge-all |
| cmd_ap | output | 1 | Auto-precharge flag of a read/write |
| cmd_cs | output | CS_W | Chip select of the command |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row of an activate |
| bank_open | output | NUM_CS*NUM_BANK | Open flag per flat bank index |

## Verification
The hardest case to reach from the ports is two banks past their idle limit at the same moment. The block only precharges an idle bank when it has no transaction to serve, so expiries normally come out one at a time. The stimulus opens two banks, then keeps the block busy with back-to-back page hits to a third bank until both have passed the limit. When the requests stop, the precharge order shows the lowest-index-first rule. A refresh pulse landing inside a precharge-activate-read/write sequence is brought about in the same way: it is driven in the cycle the precharge appears.

// File: rtl/pgtrk_pkg.sv
package pgtrk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PRE  = 3'd1,
        CMD_ACT  = 3'd2,
        CMD_RW   = 3'd3,
        CMD_PREA = 3'd4
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ACC_HIT      = 2'd0,
        ACC_EMPTY    = 2'd1,
        ACC_CONFLICT = 2'd2
    } acc_class_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ACT  = 2'd1,
        SQ_RW   = 2'd2
    } seq_state_e;

    function automatic acc_class_e classify(input logic is_open, input logic row_eq);
        if (!is_open)
            return ACC_EMPTY;
        else if (row_eq)
            return ACC_HIT;
        else
            return ACC_CONFLICT;
    endfunction

    function automatic logic closed_page(input logic ap_for_cs, input logic limit_zero);
        return ap_for_cs | limit_zero;
    endfunction

endpackage

// File: rtl/pgtrk_bank_table.sv
module pgtrk_bank_table #(
    parameter int NB    = 8,
    parameter int ROW_W = 13,
    parameter int CNT_W = 8,
    parameter int IDX_W = $clog2(NB)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear_all,
    input  logic                  op_valid,
    input  logic [IDX_W-1:0]      op_idx,
    input  logic [ROW_W-1:0]      op_row,
    input  logic                  op_set,
    input  logic                  op_clr,
    input  logic [CNT_W-1:0]      idle_limit,
    output logic [NB-1:0]         open_vec,
    output logic [NB-1:0][ROW_W-1:0] rows,
    output logic [NB-1:0]         expired_vec
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic limit_on;
    assign limit_on = (idle_limit != '0);

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic             open_q;
        logic [ROW_W-1:0] row_q;
        logic [CNT_W-1:0] cnt_q;
        logic             sel;

        assign sel = op_valid && (op_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q <= 1'b0;
                row_q  <= '0;
                cnt_q  <= '0;
            end else if (clear_all) begin
                open_q <= 1'b0;
                cnt_q  <= '0;
            end else if (sel) begin
                if (op_set) begin
                    open_q <= 1'b1;
                    row_q  <= op_row;
                end else if (op_clr) begin
                    open_q <= 1'b0;
                end
                cnt_q <= '0;
            end else if (open_q && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        assign open_vec[g]    = open_q;
        assign rows[g]        = row_q;
        assign expired_vec[g] = open_q && limit_on && (cnt_q >= idle_limit);
    end

endmodule

// File: rtl/pgtrk_lowest.sv
module pgtrk_lowest #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pgtrk_seq.sv
module pgtrk_seq
    import pgtrk_pkg::*;
#(
    parameter int CS_W   = 1,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int IDX_W  = CS_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  acc_class_e        req_class,
    input  logic              req_closed,
    input  logic              refresh_due,
    input  logic              exp_found,
    input  logic [IDX_W-1:0]  exp_idx,
    output logic              req_ready,
    output cmd_kind_e         cmd_kind,
    output logic              cmd_ap,
    output logic [CS_W-1:0]   cmd_cs,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic              clear_all,
    output logic              op_valid,
    output logic [IDX_W-1:0]  op_idx,
    output logic [ROW_W-1:0]  op_row,
    output logic              op_set,
    output logic              op_clr
);
    seq_state_e        state_q, state_d;
    logic              rfsh_pend_q, rfsh_pend_d;
    logic [CS_W-1:0]   p_cs_q, p_cs_d;
    logic [BANK_W-1:0] p_bank_q, p_bank_d;
    logic [ROW_W-1:0]  p_row_q, p_row_d;
    logic              p_ap_q, p_ap_d;

    cmd_kind_e         kind_d;
    logic              ap_d;
    logic [CS_W-1:0]   cs_d;
    logic [BANK_W-1:0] bank_d;
    logic [ROW_W-1:0]  row_d;

    logic rfsh_now;
    assign rfsh_now  = refresh_due || rfsh_pend_q;
    assign req_ready = (state_q == SQ_IDLE) && !rfsh_now;

    always_comb begin
        state_d     = state_q;
        rfsh_pend_d = rfsh_pend_q;
        p_cs_d      = p_cs_q;
        p_bank_d    = p_bank_q;
        p_row_d     = p_row_q;
        p_ap_d      = p_ap_q;
        kind_d      = CMD_NOP;
        ap_d        = 1'b0;
        cs_d        = '0;
        bank_d      = '0;
        row_d       = '0;
        clear_all   = 1'b0;
        op_valid    = 1'b0;
        op_idx      = {p_cs_q, p_bank_q};
        op_row      = p_row_q;
        op_set      = 1'b0;
        op_clr      = 1'b0;

        unique case (state_q)
            SQ_IDLE: begin
                if (rfsh_now) begin
                    kind_d      = CMD_PREA;
                    clear_all   = 1'b1;
                    rfsh_pend_d = 1'b0;
                end else if (req_valid) begin
                    p_cs_d   = req_cs;
                    p_bank_d = req_bank;
                    p_row_d  = req_row;
                    p_ap_d   = req_closed;
                    cs_d     = req_cs;
                    bank_d   = req_bank;
                    op_valid = 1'b1;
                    op_idx   = {req_cs, req_bank};
                    op_row   = req_row;
                    unique case (req_class)
                        ACC_HIT: begin
                            kind_d = CMD_RW;
                            ap_d   = req_closed;
                            op_clr = req_closed;
                        end
                        ACC_EMPTY: begin
                            kind_d  = CMD_ACT;
                            row_d   = req_row;
                            op_set  = 1'b1;
                            state_d = SQ_RW;
                        end
                        default: begin
                            kind_d  = CMD_PRE;
                            op_clr  = 1'b1;
                            state_d = SQ_ACT;
                        end
                    endcase
                end else if (exp_found) begin
                    kind_d   = CMD_PRE;
                    cs_d     = exp_idx[IDX_W-1:BANK_W];
                    bank_d   = exp_idx[BANK_W-1:0];
                    op_valid = 1'b1;
                    op_idx   = exp_idx;
                    op_clr   = 1'b1;
                end
            end
            SQ_ACT: begin
                kind_d   = CMD_ACT;
                cs_d     = p_cs_q;
                bank_d   = p_bank_q;
                row_d    = p_row_q;
                op_valid = 1'b1;
                op_set   = 1'b1;
                state_d  = SQ_RW;
            end
            default: begin
                kind_d   = CMD_RW;
                ap_d     = p_ap_q;
                cs_d     = p_cs_q;
                bank_d   = p_bank_q;
                op_valid = 1'b1;
                op_clr   = p_ap_q;
                state_d  = SQ_IDLE;
            end
        endcase

        if (state_q != SQ_IDLE && refresh_due)
            rfsh_pend_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SQ_IDLE;
            rfsh_pend_q <= 1'b0;
            p_cs_q      <= '0;
            p_bank_q    <= '0;
            p_row_q     <= '0;
            p_ap_q      <= 1'b0;
            cmd_kind    <= CMD_NOP;
            cmd_ap      <= 1'b0;
            cmd_cs      <= '0;
            cmd_bank    <= '0;
            cmd_row     <= '0;
        end else begin
            state_q     <= state_d;
            rfsh_pend_q <= rfsh_pend_d;
            p_cs_q      <= p_cs_d;
            p_bank_q    <= p_bank_d;
            p_row_q     <= p_row_d;
            p_ap_q      <= p_ap_d;
            cmd_kind    <= kind_d;
            cmd_ap      <= ap_d;
            cmd_cs      <= cs_d;
            cmd_bank    <= bank_d;
            cmd_row     <= row_d;
        end
    end

endmodule

// File: rtl/page_tracker.sv
module page_tracker
    import pgtrk_pkg::*;
#(
    parameter int NUM_CS   = 2,
    parameter int NUM_BANK = 4,
    parameter int ROW_W    = 13,
    parameter int IDLE_W   = 8,
    localparam int CS_W    = $clog2(NUM_CS),
    localparam int BANK_W  = $clog2(NUM_BANK),
    localparam int IDX_W   = CS_W + BANK_W,
    localparam int NB      = NUM_CS * NUM_BANK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              refresh_due,
    input  logic [NUM_CS-1:0] ap_en,
    input  logic [IDLE_W-1:0] idle_limit,
    output logic              cmd_valid,
    output logic [2:0]        cmd_kind,
    output logic              cmd_ap,
    output logic [CS_W-1:0]   cmd_cs,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [NB-1:0]     bank_open
);
    logic [NB-1:0]            open_vec;
    logic [NB-1:0][ROW_W-1:0] rows;
    logic [NB-1:0]            expired_vec;
    logic                     exp_found;
    logic [IDX_W-1:0]         exp_idx;
    logic                     clear_all, op_valid, op_set, op_clr;
    logic [IDX_W-1:0]         op_idx;
    logic [ROW_W-1:0]         op_row;
    logic [IDX_W-1:0]         req_idx;
    acc_class_e               req_class;
    logic                     req_closed;
    cmd_kind_e                kind;

    assign req_idx    = {req_cs, req_bank};
    assign req_class  = classify(open_vec[req_idx], rows[req_idx] == req_row);
    assign req_closed = closed_page(ap_en[req_cs], idle_limit == '0);

    pgtrk_bank_table #(
        .NB(NB), .ROW_W(ROW_W), .CNT_W(IDLE_W), .IDX_W(IDX_W)
    ) table_i (
        .clk(clk), .rst(rst), .clear_all(clear_all),
        .op_valid(op_valid), .op_idx(op_idx), .op_row(op_row),
        .op_set(op_set), .op_clr(op_clr), .idle_limit(idle_limit),
        .open_vec(open_vec), .rows(rows), .expired_vec(expired_vec)
    );

    pgtrk_lowest #(.N(NB), .IW(IDX_W)) pick_i (
        .vec(expired_vec), .found(exp_found), .idx(exp_idx)
    );

    pgtrk_seq #(
        .CS_W(CS_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .IDX_W(IDX_W)
    ) seq_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_cs(req_cs), .req_bank(req_bank),
        .req_row(req_row), .req_class(req_class), .req_closed(req_closed),
        .refresh_due(refresh_due), .exp_found(exp_found), .exp_idx(exp_idx),
        .req_ready(req_ready), .cmd_kind(kind), .cmd_ap(cmd_ap),
        .cmd_cs(cmd_cs), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .clear_all(clear_all), .op_valid(op_valid), .op_idx(op_idx),
        .op_row(op_row), .op_set(op_set), .op_clr(op_clr)
    );

    assign cmd_kind  = kind;
    assign cmd_valid = (kind != CMD_NOP);
    assign bank_open = open_vec;

endmodule

// File: rtl/pgtrk_checker.sv
module pgtrk_checker #(
    parameter int CS_W   = 1,
    parameter int BANK_W = 2,
    parameter int NB     = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic [2:0]        cmd_kind,
    input logic              cmd_ap,
    input logic [CS_W-1:0]   cmd_cs,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [NB-1:0]     bank_open
);
    logic tgt_open;
    assign tgt_open = bank_open[{cmd_cs, cmd_bank}];

    assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == 3'd2) |-> tgt_open);

    assert_rw_keeps_open_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == 3'd3 && !cmd_ap) |-> tgt_open);

    assert_rw_ap_closes_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == 3'd3 && cmd_ap) |-> !tgt_open);

    assert_pre_closes_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == 3'd1) |-> !tgt_open);

    assert_prea_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == 3'd4) |-> (bank_open == '0));

    assert_act_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == 3'd2) |-> !req_ready);

    assert_act_then_rw_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == 3'd2) |=> (cmd_kind == 3'd3));

    assert_kind_legal_R12: assert property (@(posedge clk) disable iff (rst)
        cmd_kind <= 3'd4);
endmodule

bind page_tracker pgtrk_checker #(
    .CS_W(CS_W), .BANK_W(BANK_W), .NB(NB)
) chk_i (
    .clk(clk), .rst(rst), .req_ready(req_ready), .cmd_kind(cmd_kind),
    .cmd_ap(cmd_ap), .cmd_cs(cmd_cs), .cmd_bank(cmd_bank), .bank_open(bank_open)
);

// File: tb/page_tracker_tb_top.sv
module page_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [0:0]  req_cs = '0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic        refresh_due = 1'b0;
    logic [1:0]  ap_en = '0;
    logic [7:0]  idle_limit = 8'd200;
    logic        cmd_valid;
    logic [2:0]  cmd_kind;
    logic        cmd_ap;
    logic [0:0]  cmd_cs;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_row;
    logic [7:0]  bank_open;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    page_tracker dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_cs(req_cs), .req_bank(req_bank), .req_row(req_row),
        .refresh_due(refresh_due), .ap_en(ap_en), .idle_limit(idle_limit),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_ap(cmd_ap),
        .cmd_cs(cmd_cs), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .bank_open(bank_open)
    );

    typedef struct packed {
        logic [0:0]  cs;
        logic [1:0]  bank;
        logic [12:0] row;
        logic [2:0]  first;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{cs:1'd0, bank:2'd0, row:13'd5,    first:3'd2},
        '{cs:1'd0, bank:2'd0, row:13'd5,    first:3'd3},
        '{cs:1'd0, bank:2'd1, row:13'd5,    first:3'd2},
        '{cs:1'd0, bank:2'd0, row:13'd9,    first:3'd1},
        '{cs:1'd0, bank:2'd0, row:13'd9,    first:3'd3},
        '{cs:1'd1, bank:2'd0, row:13'd5,    first:3'd2},
        '{cs:1'd0, bank:2'd1, row:13'd5,    first:3'd3},
        '{cs:1'd1, bank:2'd0, row:13'd7,    first:3'd1},
        '{cs:1'd1, bank:2'd3, row:13'd8191, first:3'd2},
        '{cs:1'd1, bank:2'd3, row:13'd8191, first:3'd3}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge; return at the falling edge where its read/write is visible.
    task automatic run_req(input int cs, input int bank, input int row,
                           output int k0, output int k1, output int k2,
                           output int act_row, output int ap, output int rdy1);
        req_cs = 1'(cs); req_bank = 2'(bank); req_row = 13'(row);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        k0 = int'(cmd_kind); k1 = 0; k2 = 0;
        rdy1 = int'(req_ready); ap = int'(cmd_ap); act_row = int'(cmd_row);
        if (k0 == 1) begin
            @(negedge clk); k1 = int'(cmd_kind); act_row = int'(cmd_row);
            @(negedge clk); k2 = int'(cmd_kind); ap = int'(cmd_ap);
        end else if (k0 == 2) begin
            @(negedge clk); k1 = int'(cmd_kind); ap = int'(cmd_ap);
        end
    endtask

    task automatic do_refresh();
        refresh_due = 1'b1;
        @(negedge clk);
        refresh_due = 1'b0;
        chk(cmd_kind == 3'd4, "R9 refresh precharge-all", int'(cmd_kind), 4);
        chk(bank_open == 8'd0, "R9 refresh closes all", int'(bank_open), 0);
    endtask

    task automatic count_to_cmd(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (cmd_kind == 3'd0 && n < 300);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int k0, k1, k2, arow, ap, rdy, n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cmd_kind == 3'd0 && !cmd_valid, "R1 no command", int'(cmd_kind), 0);
        chk(bank_open == 8'd0, "R1 all closed", int'(bank_open), 0);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);

        // Table walk: open-page mode, limit 200
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int idx;
            v = TBL[i];
            idx = int'(v.cs) * 4 + int'(v.bank);
            run_req(int'(v.cs), int'(v.bank), int'(v.row), k0, k1, k2, arow, ap, rdy);
            if (v.first == 3'd3) begin
                chk(k0 == 3, "R3 hit gives read/write first", k0, 3);
            end else if (v.first == 3'd2) begin
                chk(k0 == 2 && k1 == 3, "R2 closed bank activate then rw", k0 * 10 + k1, 23);
                chk(arow == int'(v.row), "R2 activate row", arow, int'(v.row));
                chk(rdy == 0, "R10 busy during sequence", rdy, 0);
            end else begin
                chk(k0 == 1 && k1 == 2 && k2 == 3, "R4 conflict pre act rw",
                    k0 * 100 + k1 * 10 + k2, 123);
                chk(arow == int'(v.row), "R4 activate new row", arow, int'(v.row));
                chk(rdy == 0, "R10 busy during sequence", rdy, 0);
            end
            chk(ap == 0, "R5 no auto-precharge", ap, 0);
            chk(bank_open[idx] == 1'b1, "R12 bank open bit", int'(bank_open[idx]), 1);
        end

        // R9: refresh during a conflict sequence is held
        req_cs = 1'd0; req_bank = 2'd1; req_row = 13'd6; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(cmd_kind == 3'd1, "R4 conflict precharge", int'(cmd_kind), 1);
        refresh_due = 1'b1;
        @(negedge clk);
        refresh_due = 1'b0;
        chk(cmd_kind == 3'd2, "R9 activate not preempted", int'(cmd_kind), 2);
        @(negedge clk);
        chk(cmd_kind == 3'd3, "R9 rw not preempted", int'(cmd_kind), 3);
        chk(req_ready == 1'b0, "R10 ready low while refresh waits", int'(req_ready), 0);
        @(negedge clk);
        chk(cmd_kind == 3'd4, "R9 held refresh issued", int'(cmd_kind), 4);
        chk(bank_open == 8'd0, "R9 all closed", int'(bank_open), 0);
        run_req(0, 0, 9, k0, k1, k2, arow, ap, rdy);
        chk(k0 == 2, "R9 access after refresh activates", k0, 2);

        // R6: per chip select auto-precharge
        ap_en = 2'b10;
        run_req(1, 2, 3, k0, k1, k2, arow, ap, rdy);
        chk(ap == 1, "R6 cs1 auto-precharge", ap, 1);
        chk(bank_open[6] == 1'b0, "R6 cs1 bank closed", int'(bank_open[6]), 0);
        run_req(0, 2, 3, k0, k1, k2, arow, ap, rdy);
        chk(ap == 0, "R6 cs0 unaffected", ap, 0);
        chk(bank_open[2] == 1'b1, "R6 cs0 bank open", int'(bank_open[2]), 1);
        ap_en = 2'b00;

        // R7: zero limit disables page mode
        idle_limit = 8'd0;
        run_req(0, 1, 4, k0, k1, k2, arow, ap, rdy);
        chk(ap == 1, "R7 zero limit auto-precharge", ap, 1);
        chk(bank_open[1] == 1'b0, "R7 bank closed", int'(bank_open[1]), 0);
        run_req(0, 2, 3, k0, k1, k2, arow, ap, rdy);
        chk(k0 == 3 && ap == 1, "R7 hit with auto-precharge", k0 * 10 + ap, 31);
        chk(bank_open[2] == 1'b0, "R7 hit closes bank", int'(bank_open[2]), 0);
        repeat (20) @(negedge clk);
        chk(bank_open[0] == 1'b1, "R7 no idle precharge", int'(bank_open[0]), 1);

        // R8: idle limit closes, access restarts count
        do_refresh();
        idle_limit = 8'd5;
        run_req(0, 3, 1, k0, k1, k2, arow, ap, rdy);
        count_to_cmd(n);
        chk(n == 6, "R8 idle precharge timing", n, 6);
        chk(cmd_kind == 3'd1 && cmd_bank == 2'd3 && cmd_cs == 1'd0,
            "R8 idle precharge target", int'(cmd_kind) * 10 + int'(cmd_bank), 13);
        chk(bank_open[3] == 1'b0, "R8 bank closed", int'(bank_open[3]), 0);
        run_req(0, 3, 1, k0, k1, k2, arow, ap, rdy);
        repeat (3) @(negedge clk);
        run_req(0, 3, 1, k0, k1, k2, arow, ap, rdy);
        chk(k0 == 3, "R8 hit before limit", k0, 3);
        count_to_cmd(n);
        chk(n == 6, "R8 count restarted by access", n, 6);

        // R11: simultaneous expiries, requests first, lowest index first
        do_refresh();
        idle_limit = 8'd3;
        run_req(1, 1, 2, k0, k1, k2, arow, ap, rdy);
        run_req(0, 2, 2, k0, k1, k2, arow, ap, rdy);
        run_req(0, 0, 2, k0, k1, k2, arow, ap, rdy);
        for (int j = 0; j < 5; j++) begin
            run_req(0, 0, 2, k0, k1, k2, arow, ap, rdy);
            chk(k0 == 3, "R11 request served before expiry", k0, 3);
        end
        @(negedge clk);
        chk(cmd_kind == 3'd1 && cmd_cs == 1'd0 && cmd_bank == 2'd2,
            "R11 lowest index first", int'(cmd_cs) * 4 + int'(cmd_bank), 2);
        @(negedge clk);
        chk(cmd_kind == 3'd1 && cmd_cs == 1'd1 && cmd_bank == 2'd1,
            "R11 second expiry next cycle", int'(cmd_cs) * 4 + int'(cmd_bank), 5);
        chk(bank_open == 8'b0000_0001, "R12 only bank 0 left open", int'(bank_open), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule